// File: doc/BRIEF.md
# MDIO Single-Command Management Engine

This block is a management master for a Clause 22 MDIO bus that runs one read or one write transaction each time software asks for it. Software writes a 32-bit command word that carries a go bit, the operation type, a two-bit PHY selector, a five-bit register number and sixteen bits of write data. The engine then serialises a 64-bit management frame onto the MDIO line and steps one bit for each MDC falling-edge strobe. Both MDC strobes come from a clock generator outside the block.

The five-bit PHY address in the frame has its upper three bits tied to zero. Only its two low bits come from the command word. On a read, the engine releases the line for the turnaround and the sixteen data bits. It shifts in the data bits on the MDC rising-edge strobe and copies the result into a read-data register when the frame ends. At the end of every frame the go bit clears itself, so software polls the command word to learn when the transaction is done. Command writes that arrive while go is set are dropped. A write that lands in the very clock in which the frame ends is accepted.

The controller is a single state machine. Its states are ST_IDLE, ST_PRE (preamble), ST_SOF (start code), ST_OPC (opcode), ST_PHY (PHY address), ST_REG (register address), ST_TA (turnaround) and ST_DAT (data). Each falling strobe advances the state machine by one bit. The transitions are:
- ST_IDLE to ST_PRE, on a falling strobe while go is set.
- Each field state to the next field state, after the field's last bit, in this order: ST_PRE, ST_SOF, ST_OPC, ST_PHY, ST_REG, ST_TA, ST_DAT.
- ST_DAT back to ST_IDLE, after the sixteenth data bit. This transition raises the completion pulse.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command word reads 0, the read-data register reads 0, mdio_oe is 0 and no frame is in progress.
- R2: The command word layout is: bit 0 go, bit 1 operation (1 = write, 0 = read), bits 9:8 PHY address bits 1:0, bits 14:10 register address, bits 31:16 write data. Bits 15 and 7:2 always read back as 0. A write while go is clear is stored at once.
- R3: After go is set, the first falling strobe starts the frame. Each falling strobe then drives one frame bit. The bits are: 32 ones, then start code 0 then 1, then opcode 1,0 for a read or 0,1 for a write, then the PHY address MSB first, then the register address MSB first. PHY address bits 4:2 are always 0 and bits 1:0 equal command bits 9:8.
- R4: On a write, the turnaround drives 1 then 0, and the sixteen data bits drive command bits 31:16 MSB first. mdio_oe stays 1 for all 64 bits.
- R5: On a read, mdio_oe is 0 during the two turnaround bits and the sixteen data bits. mdio_i is sampled on each rising strobe during the data bits, MSB first. The captured value appears in rd_data when the frame completes.
- R6: mdio_o and mdio_oe change only in the clock after a falling strobe.
- R7: While no frame is in progress, mdio_oe is 0, even when strobes arrive.
- R8: go stays 1 for the whole frame. It clears, and mdio_oe drops to 0, on the falling strobe that follows the last data bit.
- R9: A command write while go is set is ignored: the command word and the running frame are unchanged.
- R10: A command write in the same clock as the completing falling strobe is accepted. If it sets go, a new frame starts on the next falling strobe.
- R11: rd_data keeps its value through write operations and through ignored command writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_rise | input | 1 | One-clock strobe marking an MDC rising edge |
| mdc_fall | input | 1 | One-clock strobe marking an MDC falling edge |
| cmd_we | input | 1 | Command word write enable |
| cmd_wdata | input | 32 | Command word write value |
| cmd_word | output | 32 | Current command word, go bit included |
| rd_data | output | 16 | Data captured by the last read |
| mdio_i | input | 1 | MDIO line input |
| mdio_o | output | 1 | MDIO line output value |
| mdio_oe | output | 1 | MDIO output enable (1 = engine drives the line) |

## Verification
The completion of a frame and a new command write can fall in the same clock. Completion clears go and releases the line, while the write tries to load a new command word. The bench provokes this by raising cmd_we in the same clock as the 65th falling strobe of a frame, once with go set in the new word and once with go clear. It judges the result from the command word read back afterwards and from whether a fresh frame with the new fields then runs. A write raised in the middle of a frame is checked the opposite way: both the command word and the bits still on the line must be unaffected.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    // command word field positions
    localparam int GO_BIT   = 0;
    localparam int WR_BIT   = 1;
    localparam int PHY_LSB  = 8;
    localparam int PHY_W    = 2;
    localparam int REG_LSB  = 10;
    localparam int REG_W    = 5;
    localparam int WD_LSB   = 16;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int CMD_W    = 32;

    // bits that are stored; the rest read back as zero
    localparam logic [CMD_W-1:0] CMD_MASK = 32'hFFFF_7F03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_OPC,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_DAT
    } frame_state_e;

endpackage

// File: rtl/mdio_cmd_reg.sv
`timescale 1ns/1ps
module mdio_cmd_reg
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             done,
    output logic [CMD_W-1:0] cmd_q
);

    logic accept;

    // a write lands when idle, or in the very cycle the frame completes
    assign accept = cmd_we && (!cmd_q[GO_BIT] || done);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            if (done)
                cmd_q[GO_BIT] <= 1'b0;
            if (accept)
                cmd_q <= cmd_wdata & CMD_MASK;
        end
    end

    // R8
    go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(cmd_we && cmd_wdata[GO_BIT])) |=> !cmd_q[GO_BIT]);

    // R9
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q[GO_BIT] && cmd_we && !done) |=> $stable(cmd_q));

endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_fall,
    input  logic              go,
    input  logic              is_write,
    input  logic [PHY_W-1:0]  phy_lo,
    input  logic [REG_W-1:0]  regad,
    input  logic [DATA_W-1:0] wdata,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              sample_en,
    output logic              busy
);

    localparam int CW = (PREAMBLE_LEN > DATA_W) ? $clog2(PREAMBLE_LEN) : $clog2(DATA_W);

    frame_state_e  state, nxt_state;
    logic [CW-1:0] cnt, nxt_cnt;
    logic          done_c;
    logic          bit_c, oe_c;
    logic [ADDR_W-1:0] phy_sh, reg_sh;
    logic [DATA_W-1:0] wd_sh;

    function automatic int field_last(frame_state_e s);
        case (s)
            ST_PRE:                 return PREAMBLE_LEN - 1;
            ST_SOF, ST_OPC, ST_TA:  return 1;
            ST_PHY, ST_REG:         return ADDR_W - 1;
            ST_DAT:                 return DATA_W - 1;
            default:                return 0;
        endcase
    endfunction

    function automatic frame_state_e field_next(frame_state_e s);
        case (s)
            ST_PRE:  return ST_SOF;
            ST_SOF:  return ST_OPC;
            ST_OPC:  return ST_PHY;
            ST_PHY:  return ST_REG;
            ST_REG:  return ST_TA;
            ST_TA:   return ST_DAT;
            default: return ST_IDLE;
        endcase
    endfunction

    // next position in the frame, taken on each falling strobe
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        done_c    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    nxt_state = ST_PRE;
                    nxt_cnt   = '0;
                end
            end
            ST_PRE, ST_SOF, ST_OPC, ST_PHY, ST_REG, ST_TA, ST_DAT: begin
                if (int'(cnt) == field_last(state)) begin
                    nxt_state = field_next(state);
                    nxt_cnt   = '0;
                    done_c    = (state == ST_DAT);
                end else begin
                    nxt_cnt = cnt + CW'(1);
                end
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (mdc_fall) begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // bit and enable belonging to the position being entered
    always_comb begin
        phy_sh = {{(ADDR_W-PHY_W){1'b0}}, phy_lo} << nxt_cnt;
        reg_sh = regad << nxt_cnt;
        wd_sh  = wdata << nxt_cnt;
        bit_c  = 1'b1;
        oe_c   = 1'b1;
        unique case (nxt_state)
            ST_IDLE: begin bit_c = 1'b1; oe_c = 1'b0; end
            ST_PRE:  bit_c = 1'b1;
            ST_SOF:  bit_c = (nxt_cnt != '0);
            ST_OPC:  bit_c = is_write ? (nxt_cnt != '0) : (nxt_cnt == '0);
            ST_PHY:  bit_c = phy_sh[ADDR_W-1];
            ST_REG:  bit_c = reg_sh[ADDR_W-1];
            ST_TA: begin
                bit_c = is_write ? (nxt_cnt == '0) : 1'b1;
                oe_c  = is_write;
            end
            ST_DAT: begin
                bit_c = is_write ? wd_sh[DATA_W-1] : 1'b1;
                oe_c  = is_write;
            end
        endcase
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (mdc_fall) begin
            mdio_o  <= bit_c;
            mdio_oe <= oe_c;
        end
    end

    assign done      = mdc_fall && done_c;
    assign sample_en = (state == ST_DAT) && !is_write;
    assign busy      = (state != ST_IDLE);

    // R6
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mdc_fall |=> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mdio_oe);

    // R3
    phy_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PHY && int'(cnt) < (ADDR_W - PHY_W)) |-> (mdio_oe && !mdio_o));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TA || state == ST_DAT) && !is_write) |-> !mdio_oe);

endmodule

// File: rtl/mdio_rd_capture.sv
`timescale 1ns/1ps
module mdio_rd_capture
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_rise,
    input  logic              sample_en,
    input  logic              mdio_i,
    input  logic              load,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            rd_data <= '0;
        end else begin
            if (sample_en && mdc_rise)
                shift_q <= {shift_q[DATA_W-2:0], mdio_i};
            if (load)
                rd_data <= shift_q;
        end
    end

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rd_data));

endmodule

// File: rtl/mdio_cmd_engine.sv
`timescale 1ns/1ps
module mdio_cmd_engine
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_rise,
    input  logic              mdc_fall,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  cmd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);

    logic [CMD_W-1:0] cmd_q;
    logic             done, sample_en, busy;

    mdio_cmd_reg u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .done      (done),
        .cmd_q     (cmd_q)
    );

    mdio_frame_fsm #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc_fall  (mdc_fall),
        .go        (cmd_q[GO_BIT]),
        .is_write  (cmd_q[WR_BIT]),
        .phy_lo    (cmd_q[PHY_LSB +: PHY_W]),
        .regad     (cmd_q[REG_LSB +: REG_W]),
        .wdata     (cmd_q[WD_LSB +: DATA_W]),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .sample_en (sample_en),
        .busy      (busy)
    );

    mdio_rd_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc_rise  (mdc_rise),
        .sample_en (sample_en),
        .mdio_i    (mdio_i),
        .load      (done && !cmd_q[WR_BIT]),
        .rd_data   (rd_data)
    );

    assign cmd_word = cmd_q;

    // R8
    busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cmd_q[GO_BIT]);

endmodule

// File: tb/sim_mdio_cmd_engine.sv
`timescale 1ns/1ps
module sim_mdio_cmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc_rise = 1'b0, mdc_fall = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_word;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;
    logic        mdio_o, mdio_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mdio_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .mdc_fall(mdc_fall),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_word(cmd_word),
        .rd_data(rd_data), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(logic [31:0] w);
        return w & 32'hFFFF_7F03;
    endfunction

    function automatic logic [63:0] frame_of(logic [31:0] w);
        logic wr = w[1];
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), 3'b000, w[9:8],
                w[14:10], (wr ? 2'b10 : 2'b00), (wr ? w[31:16] : 16'h0000)};
    endfunction

    task automatic pulse_fall(input bit with_write, input logic [31:0] w);
        @(negedge clk);
        mdc_fall = 1'b1;
        if (with_write) begin cmd_we = 1'b1; cmd_wdata = w; end
        @(negedge clk);
        mdc_fall = 1'b0;
        cmd_we = 1'b0;
    endtask

    task automatic pulse_rise();
        @(negedge clk); mdc_rise = 1'b1;
        @(negedge clk); mdc_rise = 1'b0;
    endtask

    task automatic write_cmd(input logic [31:0] w);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    // w must have go set; runs 64 bits plus the completing strobe
    task automatic run_op(input logic [31:0] w, input bit do_write, input bit busy_poke,
                          input bit collide, input logic [31:0] cw, input logic [15:0] phy_data);
        logic [63:0] f;
        logic [15:0] prev_rd;
        logic        so, soe;
        string       tag;
        if (do_write) begin
            write_cmd(w);
            check(cmd_word == exp_word(w), "R2", "command readback", cmd_word, exp_word(w));
        end
        prev_rd = rd_data;
        f = frame_of(w);
        for (int k = 0; k < 64; k++) begin
            pulse_fall(1'b0, '0);
            tag = (k < 46) ? "R3" : (w[1] ? "R4" : "R5");
            check(mdio_oe == (w[1] || k < 46), tag, $sformatf("oe bit %0d", k),
                  32'(mdio_oe), 32'(w[1] || k < 46));
            if (w[1] || k < 46)
                check(mdio_o == f[63-k], tag, $sformatf("mdio bit %0d", k),
                      32'(mdio_o), 32'(f[63-k]));
            so = mdio_o; soe = mdio_oe;
            if (!w[1] && k >= 48) mdio_i = phy_data[63-k];
            else                  mdio_i = 1'($urandom);
            if (busy_poke && k == 20) begin
                write_cmd($urandom);
                check(cmd_word == exp_word(w), "R9", "write while busy", cmd_word, exp_word(w));
            end
            @(negedge clk);
            pulse_rise();
            check(mdio_o == so && mdio_oe == soe, "R6", "stable after rise",
                  {30'd0, mdio_oe, mdio_o}, {30'd0, soe, so});
        end
        pulse_fall(collide, cw);
        check(mdio_oe == 1'b0, "R8", "release at end", 32'(mdio_oe), 32'd0);
        if (collide)
            check(cmd_word == exp_word(cw), "R10", "write at completion", cmd_word, exp_word(cw));
        else
            check(cmd_word[0] == 1'b0, "R8", "go self-clear", 32'(cmd_word[0]), 32'd0);
        if (w[1])
            check(rd_data == prev_rd, "R11", "rd_data held on write", 32'(rd_data), 32'(prev_rd));
        else
            check(rd_data == phy_data, "R5", "read capture", 32'(rd_data), 32'(phy_data));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cmd_word == 32'd0, "R1", "cmd after reset", cmd_word, 32'd0);
        check(rd_data == 16'd0, "R1", "rd_data after reset", 32'(rd_data), 32'd0);
        check(mdio_oe == 1'b0, "R1", "oe after reset", 32'(mdio_oe), 32'd0);
        // R7 strobes while idle
        for (int i = 0; i < 3; i++) begin
            pulse_fall(1'b0, '0);
            pulse_rise();
            check(mdio_oe == 1'b0, "R7", "oe idle", 32'(mdio_oe), 32'd0);
        end
        // R2 write with go clear: stored, reserved bits zero, nothing starts
        write_cmd(32'hFFFF_FFFE);
        check(cmd_word == 32'hFFFF_7F02, "R2", "reserved bits", cmd_word, 32'hFFFF_7F02);
        pulse_fall(1'b0, '0);
        check(mdio_oe == 1'b0, "R7", "no start without go", 32'(mdio_oe), 32'd0);
        // directed write and read
        run_op(32'hA5C3_0B03, 1'b1, 1'b0, 1'b0, '0, 16'h0000);
        run_op(32'h0000_7F01, 1'b1, 1'b0, 1'b0, '0, 16'hBEEF);
        run_op(32'h0000_0001, 1'b1, 1'b1, 1'b0, '0, 16'h8001);
        // R11 write op after read keeps rd_data, with a busy poke
        run_op(32'h1234_2603, 1'b1, 1'b1, 1'b0, '0, 16'h0000);
        // R10 completion collides with a write carrying go
        run_op(32'h0000_5201, 1'b1, 1'b0, 1'b1, 32'h5A5A_1D03, 16'h7E81);
        run_op(32'h5A5A_1D03, 1'b0, 1'b0, 1'b1, 32'h0000_4300, 16'h0000);
        check(mdio_oe == 1'b0, "R10", "no start when go clear", 32'(mdio_oe), 32'd0);
        // random operations
        for (int n = 0; n < 20; n++) begin
            logic [31:0] w;
            w = $urandom | 32'd1;
            run_op(w, 1'b1, 1'($urandom), 1'b0, '0, 16'($urandom));
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule